// File: doc/BRIEF.md
# Host Controller Interrupt Status and Enable

This block collects the interrupt causes of a USB host controller. Each hardware event arrives as a one-cycle pulse and sets a sticky status bit. Only software can clear a status bit, by writing a one to its position through a small register port. Software cannot set a status bit.

An enable register selects which causes may interrupt, and a master enable bit gates all of them together. The qualified causes drive a registered, level-sensitive interrupt output. The ownership-change cause takes a separate route. Its own enable bit selects it onto a system management interrupt (SMI) output, and it never reaches the normal interrupt. A parameter can leave out SMI support. In that case the ownership-change status and enable bits read as zero and the SMI output stays low.

The register port is word addressed with two address bits. Reads are combinational from the current register state. A write takes effect on the clock edge at which `regWrEn` is high.

Top module: `hc_irq_unit`

## Requirements
- R1: After reset, every status bit, every enable bit, `irqOut` and `smiOut` are 0.
- R2: An event pulse on `evtPulse[i]` sets status bit i on that edge. The bits are: 0 scheduling overrun, 1 done-queue writeback, 2 start of frame, 3 resume detected, 4 unrecoverable error, 5 frame number overflow, 6 root hub status change. A set bit stays set until software clears it.
- R3: A write to address 0 clears each status bit whose data bit is 1. Bits written 0 keep their value, and no write to address 0 can set a status bit.
- R4: If an event pulse and a software clear hit the same status bit on the same edge, the bit ends up set.
- R5: Status bits 7 to 29 and bit 31, and enable bits 7 to 29, always read 0, and writes to them are ignored. Address 3 reads 0 and writes to it change nothing.
- R6: A write to address 1 sets each enable bit whose data bit is 1. A write to address 2 clears each enable bit whose data bit is 1. Addresses 1 and 2 both read the enable register. Enable bit 31 is the master enable.
- R7: `irqOut` goes high one cycle after the register state holds a status bit among 0 to 6 with its enable bit set and the master enable set. It stays low if any of the three is missing.
- R8: `irqOut` and `smiOut` fall one cycle after their last qualifying condition is removed.
- R9: A pulse on `ocReq` sets status bit 30. `smiOut` is high one cycle after status bit 30 and enable bit 30 are both set, whatever the master enable holds. Bit 30 never drives `irqOut`.
- R10: With SMI support off, status bit 30 and enable bit 30 read 0 and `smiOut` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | EVT_NUM (7) | One-cycle hardware event pulses, one per status bit 0 to 6 |
| ocReq | input | 1 | One-cycle pulse: ownership change requested |
| regAddr | input | 2 | Register word address: 0 status, 1 enable set, 2 enable clear |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | REG_W (32) | Register write data |
| regRdData | output | REG_W (32) | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Registered normal interrupt level |
| smiOut | output | 1 | Registered system management interrupt level |

## Verification
Status and enable changes are visible on `regRdData` at the first falling edge after the edge that applied the pulse or write. `irqOut` and `smiOut` follow one full cycle after that. Each stimulus task returns just after its active edge. Each expected item is queued for a particular falling edge: the first one after the stimulus for readback, the next one for the interrupt outputs. A monitor compares each item 1 ns after its falling edge. This catches both a missing interrupt register stage and an extra one. A second instance with SMI support off receives the same stimulus and is checked against its own expected values.

// File: rtl/hcirq_pkg.sv
package hcirq_pkg;

  localparam int REG_W   = 32;
  localparam int OC_BIT  = 30;
  localparam int MIE_BIT = 31;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENSET  = 2'd1,
    SEL_ENCLR  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_t;

  typedef struct packed {
    logic [REG_W-1:0] stsClr;
    logic [REG_W-1:0] enSet;
    logic [REG_W-1:0] enClr;
  } ctrlStrobes_t;

endpackage

// File: rtl/hcirq_ctrl.sv
module hcirq_ctrl
  import hcirq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output ctrlStrobes_t      strobes,
  output regSel_t           rdSel
);

  regSel_t addrSel;

  always_comb begin
    case (regAddr)
      2'd0:    addrSel = SEL_STATUS;
      2'd1:    addrSel = SEL_ENSET;
      2'd2:    addrSel = SEL_ENCLR;
      default: addrSel = SEL_NONE;
    endcase
  end

  assign rdSel = addrSel;

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (addrSel)
        SEL_STATUS: strobes.stsClr = regWrData;
        SEL_ENSET:  strobes.enSet  = regWrData;
        SEL_ENCLR:  strobes.enClr  = regWrData;
        default:    strobes        = '0;
      endcase
    end
  end

endmodule

// File: rtl/hcirq_dp.sv
module hcirq_dp
  import hcirq_pkg::*;
#(
  parameter int EVT_NUM     = 7,
  parameter bit SMI_SUPPORT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [EVT_NUM-1:0] evtPulse,
  input  logic               ocReq,
  input  ctrlStrobes_t       strobes,
  input  regSel_t            rdSel,
  output logic [REG_W-1:0]   rdData,
  output logic               irqOut,
  output logic               smiOut
);

  localparam logic [REG_W-1:0] EVT_MASK = (REG_W'(1) << EVT_NUM) - REG_W'(1);
  localparam logic [REG_W-1:0] OC_MASK  = SMI_SUPPORT ? (REG_W'(1) << OC_BIT) : '0;
  localparam logic [REG_W-1:0] STS_MASK = EVT_MASK | OC_MASK;
  localparam logic [REG_W-1:0] ENA_MASK = STS_MASK | (REG_W'(1) << MIE_BIT);

  logic [REG_W-1:0] hwSet;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] enableQ;
  logic             irqQ;
  logic             irqNext;

  always_comb begin
    hwSet                = '0;
    hwSet[EVT_NUM-1:0]   = evtPulse;
    hwSet[OC_BIT]        = ocReq;
  end

  // Status: one flop per implemented bit; hardware set beats software clear.
  genvar b;
  generate
    for (b = 0; b < REG_W; b++) begin : g_sts
      if (STS_MASK[b]) begin : g_impl
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)         statusQ[b] <= 1'b0;
          else if (hwSet[b]) statusQ[b] <= 1'b1;
          else if (strobes.stsClr[b]) statusQ[b] <= 1'b0;
        end
      end else begin : g_rsvd
        assign statusQ[b] = 1'b0;
      end
    end
  endgenerate

  // Enable: write-one-set and write-one-clear ports at separate addresses.
  generate
    for (b = 0; b < REG_W; b++) begin : g_ena
      if (ENA_MASK[b]) begin : g_impl
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                  enableQ[b] <= 1'b0;
          else if (strobes.enSet[b])  enableQ[b] <= 1'b1;
          else if (strobes.enClr[b])  enableQ[b] <= 1'b0;
        end
      end else begin : g_rsvd
        assign enableQ[b] = 1'b0;
      end
    end
  endgenerate

  assign irqNext = enableQ[MIE_BIT] &
                   (|(statusQ[EVT_NUM-1:0] & enableQ[EVT_NUM-1:0]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= irqNext;
  end

  assign irqOut = irqQ;

  generate
    if (SMI_SUPPORT) begin : g_smi
      logic smiQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) smiQ <= 1'b0;
        else       smiQ <= statusQ[OC_BIT] & enableQ[OC_BIT];
      end
      assign smiOut = smiQ;
    end else begin : g_nosmi
      assign smiOut = 1'b0;
    end
  endgenerate

  always_comb begin
    case (rdSel)
      SEL_STATUS:          rdData = statusQ;
      SEL_ENSET, SEL_ENCLR: rdData = enableQ;
      default:             rdData = '0;
    endcase
  end

endmodule

// File: rtl/hc_irq_unit.sv
module hc_irq_unit
  import hcirq_pkg::*;
#(
  parameter int EVT_NUM     = 7,
  parameter bit SMI_SUPPORT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [EVT_NUM-1:0] evtPulse,
  input  logic               ocReq,
  input  logic [1:0]         regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               irqOut,
  output logic               smiOut
);

  ctrlStrobes_t strobes;
  regSel_t      rdSel;

  hcirq_ctrl u_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobes   (strobes),
    .rdSel     (rdSel)
  );

  hcirq_dp #(
    .EVT_NUM     (EVT_NUM),
    .SMI_SUPPORT (SMI_SUPPORT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .evtPulse (evtPulse),
    .ocReq    (ocReq),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .smiOut   (smiOut)
  );

endmodule

// File: rtl/hcirq_chk.sv
module hcirq_chk #(
  parameter int EVT_NUM     = 7,
  parameter bit SMI_SUPPORT = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [EVT_NUM-1:0] evtPulse,
  input logic               ocReq,
  input logic [1:0]         regAddr,
  input logic               regWrEn,
  input logic [31:0]        regRdData,
  input logic               smiOut
);

  a_r5_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdData[29:EVT_NUM] == '0 && !regRdData[31]));

  a_r10_smi_tied: assert property (@(posedge clk) disable iff (!rstN)
    (!SMI_SUPPORT) |-> (!smiOut && !(regAddr == 2'd0 && regRdData[30])));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regAddr) == 2'd0 && regAddr == 2'd0 && !$past(regWrEn))
      |-> ((regRdData & $past(regRdData)) == $past(regRdData)));

  a_r3_no_sw_set: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regAddr) == 2'd0 && regAddr == 2'd0 &&
     $past(evtPulse) == '0 && !$past(ocReq))
      |-> ((regRdData & ~$past(regRdData)) == '0));

  a_r4_event_lands: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0)
      |-> ((regRdData[EVT_NUM-1:0] & $past(evtPulse)) == $past(evtPulse)));

endmodule

bind hc_irq_unit hcirq_chk #(
  .EVT_NUM     (EVT_NUM),
  .SMI_SUPPORT (SMI_SUPPORT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .evtPulse  (evtPulse),
  .ocReq     (ocReq),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regRdData (regRdData),
  .smiOut    (smiOut)
);

// File: tb/hc_irq_unit_tb_top.sv
module hc_irq_unit_tb_top;

  typedef struct {
    logic [1:0]  addr;
    logic [31:0] rdA;
    logic [31:0] rdB;
    logic        irq;
    logic        smiA;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  evtPulse = '0;
  logic        ocReq = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdA, rdB;
  logic        irqA, irqB, smiA, smiB;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  hc_irq_unit #(.EVT_NUM(7), .SMI_SUPPORT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .ocReq(ocReq),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(rdA), .irqOut(irqA), .smiOut(smiA));

  hc_irq_unit #(.EVT_NUM(7), .SMI_SUPPORT(1'b0)) dut_nosmi_i (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .ocReq(ocReq),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(rdB), .irqOut(irqB), .smiOut(smiB));

  task automatic cmp(string what, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per falling edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        cmp("rdData", it.tag, rdA, it.rdA);
        cmp("rdData nosmi R10", it.tag, rdB, it.rdB);
        cmp("irqOut", it.tag, {31'b0, irqA}, {31'b0, it.irq});
        cmp("irqOut nosmi", it.tag, {31'b0, irqB}, {31'b0, it.irq});
        cmp("smiOut", it.tag, {31'b0, smiA}, {31'b0, it.smiA});
        cmp("smiOut nosmi R10", it.tag, {31'b0, smiB}, 32'd0);
      end
    end
  end

  task automatic drive(logic [1:0] a, logic we, logic [31:0] d, logic [6:0] ev, logic oc);
    @(negedge clk);
    regAddr = a; regWrEn = we; regWrData = d; evtPulse = ev; ocReq = oc;
    @(posedge clk);
    #1;
    regWrEn = 1'b0; regWrData = '0; evtPulse = '0; ocReq = 1'b0;
  endtask

  task automatic obs(logic [1:0] a, logic [31:0] eA, logic [31:0] eB,
                     logic irq, logic smi, string tag);
    expItem_t it;
    @(negedge clk);
    regAddr = a; regWrEn = 1'b0;
    it.addr = a; it.rdA = eA; it.rdB = eB; it.irq = irq; it.smiA = smi; it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    obs(2'd0, 32'h0, 32'h0, 0, 0, "R1 status");
    obs(2'd1, 32'h0, 32'h0, 0, 0, "R1 enable");
    // R2: events set sticky bits
    drive(2'd0, 0, 32'h0, 7'h05, 0);
    obs(2'd0, 32'h5, 32'h5, 0, 0, "R2 set");
    obs(2'd0, 32'h5, 32'h5, 0, 0, "R2 sticky R7 no enable");
    // R6/R7: enable without master
    drive(2'd1, 1, 32'h1, 7'h0, 0);
    obs(2'd1, 32'h1, 32'h1, 0, 0, "R6 set");
    obs(2'd1, 32'h1, 32'h1, 0, 0, "R7 no master");
    drive(2'd1, 1, 32'h8000_0000, 7'h0, 0);
    obs(2'd1, 32'h8000_0001, 32'h8000_0001, 0, 0, "R7 not yet");
    obs(2'd0, 32'h5, 32'h5, 1, 0, "R7 rise");
    // R3: clear one bit, zeros and reserved bits leave state
    drive(2'd0, 1, 32'h4, 7'h0, 0);
    obs(2'd0, 32'h1, 32'h1, 1, 0, "R3 clear");
    drive(2'd0, 1, 32'hFFFF_FF80, 7'h0, 0);
    obs(2'd0, 32'h1, 32'h1, 1, 0, "R3 R5 zero and reserved");
    drive(2'd0, 1, 32'h1, 7'h0, 0);
    obs(2'd0, 32'h0, 32'h0, 1, 0, "R8 hold");
    obs(2'd0, 32'h0, 32'h0, 0, 0, "R8 fall");
    // R4: set beats clear
    drive(2'd0, 0, 32'h0, 7'h02, 0);
    obs(2'd0, 32'h2, 32'h2, 0, 0, "R2 bit1");
    drive(2'd0, 1, 32'h2, 7'h02, 0);
    obs(2'd0, 32'h2, 32'h2, 0, 0, "R4 set wins");
    drive(2'd1, 1, 32'h2, 7'h0, 0);
    obs(2'd2, 32'h8000_0003, 32'h8000_0003, 0, 0, "R6 read at clear addr");
    obs(2'd0, 32'h2, 32'h2, 1, 0, "R7 rise bit1");
    drive(2'd2, 1, 32'h8000_0000, 7'h0, 0);
    obs(2'd1, 32'h3, 32'h3, 1, 0, "R6 clear master");
    obs(2'd0, 32'h2, 32'h2, 0, 0, "R8 master off");
    drive(2'd1, 1, 32'h7FFF_FF80, 7'h0, 0);
    obs(2'd1, 32'h4000_0003, 32'h3, 0, 0, "R5 R10 enable reserved");
    // R9: ownership change to SMI
    drive(2'd0, 0, 32'h0, 7'h0, 1);
    obs(2'd0, 32'h4000_0002, 32'h2, 0, 0, "R9 status bit30");
    obs(2'd0, 32'h4000_0002, 32'h2, 0, 1, "R9 smi rise");
    drive(2'd0, 1, 32'h2, 7'h0, 0);
    obs(2'd0, 32'h4000_0000, 32'h0, 0, 1, "R3 keep bit30");
    drive(2'd1, 1, 32'h8000_0000, 7'h0, 0);
    obs(2'd1, 32'hC000_0003, 32'h8000_0003, 0, 1, "R9 master on");
    obs(2'd0, 32'h4000_0000, 32'h0, 0, 1, "R9 no irq from bit30");
    drive(2'd0, 1, 32'h4000_0000, 7'h0, 0);
    obs(2'd0, 32'h0, 32'h0, 0, 1, "R8 smi hold");
    obs(2'd0, 32'h0, 32'h0, 0, 0, "R8 smi fall");
    // R5: unused address
    obs(2'd3, 32'h0, 32'h0, 0, 0, "R5 addr3 read");
    drive(2'd3, 1, 32'hFFFF_FFFF, 7'h0, 0);
    obs(2'd0, 32'h0, 32'h0, 0, 0, "R5 addr3 write status");
    obs(2'd1, 32'hC000_0003, 32'h8000_0003, 0, 0, "R5 addr3 write enable");
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule